// File: doc/BRIEF.md
# Strobe-Captured Two-Stage Arithmetic Unit

This unit performs one of four operations on two unsigned byte operands: sum, unsigned product, bitwise OR and bitwise AND. A one-cycle start pulse, sampled on a rising clock edge, loads the operation code and both operands into a capture stage. The result is computed from the captured values and registered into an output stage. It is therefore present on the result bus one cycle after capture and is stable when the second edge after the capture edge arrives.

The unit is fully pipelined, so a caller may assert start on every cycle. Each result follows its own start by the same fixed latency. Every operation zero-extends its result to the full output width, and the number of meaningful bits depends on the operation. While start stays low, the captured values are held and the output keeps showing the result of the last started operation. An active-low synchronous reset clears both stages.

Top module: `strobe_alu`

## Requirements
- R1: On a rising edge where `start_i` is 1 and `rst_ni` is 1, `op_i`, `a_i` and `b_i` are captured, and the result is computed from those captured values, not from later input values.
- R2: On an edge where `start_i` is 0, the captured values are kept and input changes have no effect, so `res_o` keeps showing the result of the last started operation.
- R3: For a capture at edge E, `res_o` still shows the previous result after E, shows the new result after edge E+1, and holds it at edge E+2. The latency is two edges.
- R4: The operation code is encoded as 2'b00 sum, 2'b01 product, 2'b10 OR and 2'b11 AND.
- R5: Sum: `res_o[8:0]` = a + b with the carry kept in bit 8, and `res_o[15:9]` = 0 (for example, 1 + 3 gives 16'h0004 and 255 + 255 gives 16'h01FE).
- R6: Product: `res_o` is the full 16-bit unsigned product a * b (for example, 255 * 255 gives 16'hFE01).
- R7: OR and AND: `res_o[7:0]` holds the bitwise result and `res_o[15:8]` = 0.
- R8: With `start_i` high on consecutive edges, each result appears on `res_o` two edges after its own start, with no result lost or repeated.
- R9: While `rst_ni` is 0 on a rising edge, both stages are cleared and `start_i` is ignored. `res_o` reads 16'h0000 after that edge, and stays 0 after release until a start arrives.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Capture strobe for the operation and operands |
| op_i | input | 2 | Operation code |
| a_i | input | DW (8) | First operand, unsigned |
| b_i | input | DW (8) | Second operand, unsigned |
| res_o | output | 2*DW (16) | Zero-extended result |

## Verification
The bench sweeps the full operand space for sum and product, and a strided grid for OR and AND. All starts are back to back, so a design that loses its pipelining, or is one edge early or late, misplaces every result. The directed vectors target carry-out of the sum, the top bits of the product and the zeroed upper byte of the logic results. A design that truncated the carry, multiplied with signed operands or leaked into the upper byte would produce exactly these vectors wrongly. Further tests change the operands while start is low, look at the output one edge after capture to catch a result that appears too early, and assert reset with start held high to catch a design that captures during reset.

// File: rtl/strobe_alu_pkg.sv
package strobe_alu_pkg;

    localparam int SALU_DW      = 8;
    localparam int SALU_NUM_OPS = 4;
    localparam int SALU_OPW     = $clog2(SALU_NUM_OPS);

    typedef enum logic [SALU_OPW-1:0] {
        OP_SUM  = 2'b00,
        OP_PROD = 2'b01,
        OP_OR   = 2'b10,
        OP_AND  = 2'b11
    } salu_op_e;

endpackage

// File: rtl/salu_capture.sv
module salu_capture
    import strobe_alu_pkg::*;
#(
    parameter int DW = SALU_DW
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [SALU_OPW-1:0] op_i,
    input  logic [DW-1:0]       a_i,
    input  logic [DW-1:0]       b_i,
    output logic [SALU_OPW-1:0] op_o,
    output logic [DW-1:0]       a_o,
    output logic [DW-1:0]       b_o
);

    typedef struct packed {
        logic [SALU_OPW-1:0] op;
        logic [DW-1:0]       a;
        logic [DW-1:0]       b;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (start_i) begin
            cap_d.op = op_i;
            cap_d.a  = a_i;
            cap_d.b  = b_i;
        end
        if (!rst_ni) begin
            cap_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        cap_q <= cap_d;
    end

    assign op_o = cap_q.op;
    assign a_o  = cap_q.a;
    assign b_o  = cap_q.b;

endmodule

// File: rtl/salu_datapath.sv
module salu_datapath
    import strobe_alu_pkg::*;
#(
    parameter int DW = SALU_DW
) (
    input  logic [SALU_OPW-1:0] op_i,
    input  logic [DW-1:0]       a_i,
    input  logic [DW-1:0]       b_i,
    output logic [2*DW-1:0]     res_o
);

    localparam int RW = 2 * DW;
    localparam int SW = DW + 1;

    logic [RW-1:0] lane [SALU_NUM_OPS];

    // One lane per operation code; each lane zero-extends to the bus width.
    for (genvar i = 0; i < SALU_NUM_OPS; i++) begin : g_lane
        if (i == int'(OP_SUM)) begin : g_sum
            logic [SW-1:0] sum;
            assign sum     = {1'b0, a_i} + {1'b0, b_i};
            assign lane[i] = RW'(sum);
        end else if (i == int'(OP_PROD)) begin : g_prod
            assign lane[i] = RW'(a_i) * RW'(b_i);
        end else if (i == int'(OP_OR)) begin : g_or
            assign lane[i] = RW'(a_i | b_i);
        end else begin : g_and
            assign lane[i] = RW'(a_i & b_i);
        end
    end

    assign res_o = lane[op_i];

endmodule

// File: rtl/salu_outreg.sv
module salu_outreg #(
    parameter int RW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [RW-1:0] res_i,
    output logic [RW-1:0] res_o
);

    logic [RW-1:0] res_d, res_q;

    always_comb begin
        res_d = res_i;
        if (!rst_ni) begin
            res_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        res_q <= res_d;
    end

    assign res_o = res_q;

endmodule

// File: rtl/strobe_alu.sv
module strobe_alu
    import strobe_alu_pkg::*;
#(
    parameter int DW = SALU_DW
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic [SALU_OPW-1:0] op_i,
    input  logic [DW-1:0]       a_i,
    input  logic [DW-1:0]       b_i,
    output logic [2*DW-1:0]     res_o
);

    localparam int RW = 2 * DW;

    logic [SALU_OPW-1:0] cap_op;
    logic [DW-1:0]       cap_a;
    logic [DW-1:0]       cap_b;
    logic [RW-1:0]       comb_res;

    salu_capture #(.DW(DW)) u_capture (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .op_i    (op_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .op_o    (cap_op),
        .a_o     (cap_a),
        .b_o     (cap_b)
    );

    salu_datapath #(.DW(DW)) u_datapath (
        .op_i  (cap_op),
        .a_i   (cap_a),
        .b_i   (cap_b),
        .res_o (comb_res)
    );

    salu_outreg #(.RW(RW)) u_outreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .res_i  (comb_res),
        .res_o  (res_o)
    );

endmodule

// File: rtl/strobe_alu_chk.sv
module strobe_alu_chk
    import strobe_alu_pkg::*;
#(
    parameter int DW = SALU_DW
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                start_i,
    input logic [SALU_OPW-1:0] op_i,
    input logic [DW-1:0]       a_i,
    input logic [DW-1:0]       b_i,
    input logic [2*DW-1:0]     res_o
);

    localparam int RW = 2 * DW;

    // Edges seen with reset released, saturating at 3.
    logic [1:0] age_q = 2'd0;
    always_ff @(posedge clk_i) begin
        if (!rst_ni)            age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        !rst_ni |=> res_o == '0); // R9

    AST_HOLD_WITHOUT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && !$past(start_i, 2)) |-> $stable(res_o)); // R2

    AST_SUM_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(start_i, 2) && $past(op_i, 2) == OP_SUM)
        |-> res_o == RW'({1'b0, $past(a_i, 2)} + {1'b0, $past(b_i, 2)})); // R5

    AST_PROD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(start_i, 2) && $past(op_i, 2) == OP_PROD)
        |-> res_o == RW'($past(a_i, 2)) * RW'($past(b_i, 2))); // R6

    AST_LOGIC_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd3 && $past(start_i, 2) && $past(op_i[1], 2))
        |-> res_o[RW-1:DW] == '0); // R7

endmodule

bind strobe_alu strobe_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_strobe_alu.sv
module tb_strobe_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 199000;
    localparam int NVEC       = 10;

    // {op, a, b, expected}
    localparam logic [33:0] VECS [NVEC] = '{
        {2'b00, 8'd1,   8'd3,   16'h0004},
        {2'b00, 8'd255, 8'd255, 16'h01FE},
        {2'b00, 8'd128, 8'd128, 16'h0100},
        {2'b01, 8'd255, 8'd255, 16'hFE01},
        {2'b01, 8'd128, 8'd2,   16'h0100},
        {2'b01, 8'd0,   8'd200, 16'h0000},
        {2'b10, 8'hF0,  8'h0F,  16'h00FF},
        {2'b10, 8'hA5,  8'h00,  16'h00A5},
        {2'b11, 8'hFF,  8'hFF,  16'h00FF},
        {2'b11, 8'hAA,  8'h55,  16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic [7:0]  a, b;
    logic [15:0] res;

    int n_checks = 0;
    int n_errs   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobe_alu dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (start),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .res_o   (res)
    );

    function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] x, input logic [7:0] y);
        case (o)
            2'b00:   model = {7'd0, {1'b0, x} + {1'b0, y}};
            2'b01:   model = 16'(x) * 16'(y);
            2'b10:   model = {8'd0, x | y};
            default: model = {8'd0, x & y};
        endcase
    endfunction

    function automatic string op_req(input logic [1:0] o);
        case (o)
            2'b00:   op_req = "R5";
            2'b01:   op_req = "R6";
            default: op_req = "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: res=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic [1:0] o, input logic [7:0] x, input logic [7:0] y);
        start = s; op = o; a = x; b = y;
    endtask

    // Pipeline of expectations for the back-to-back sweep.
    logic        v1, v2;
    logic [15:0] e1, e2;
    logic [1:0]  o1, o2;

    task automatic stream(input logic s, input logic [1:0] o, input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        if (v2) chk({op_req(o2), "/R8"}, res, e2);
        v2 = v1; e2 = e1; o2 = o1;
        v1 = s;  e1 = model(o, x, y); o1 = o;
        drive(s, o, x, y);
    endtask

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: cycles=%0d expected<%0d", cycles, WATCHDOG);
            $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        rst_n = 1'b0;
        drive(1'b1, 2'b01, 8'hFF, 8'hFF);
        repeat (3) @(negedge clk);
        chk("R9 reset clears", res, 16'h0000);
        rst_n = 1'b1;
        drive(1'b0, 2'b01, 8'hFF, 8'hFF);
        repeat (3) @(negedge clk);
        chk("R9 no capture during reset", res, 16'h0000);

        // Directed table: capture, latency, hold with changing inputs.
        prev = 16'h0000;
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  vo;
            logic [7:0]  va, vb;
            logic [15:0] ve;
            {vo, va, vb, ve} = VECS[i];
            drive(1'b1, vo, va, vb);
            @(negedge clk);
            chk("R3 not early", res, prev);
            drive(1'b0, ~vo, ~va, vb + 8'd7);
            @(negedge clk);
            chk({"R4/", op_req(vo), "/R1"}, res, ve);
            @(negedge clk);
            drive(1'b0, vo ^ 2'b01, va + 8'd1, ~vb);
            @(negedge clk);
            @(negedge clk);
            chk("R2 hold", res, ve);
            prev = ve;
        end

        // Back-to-back sweep.
        v1 = 1'b0; v2 = 1'b0; e1 = '0; e2 = '0; o1 = '0; o2 = '0;
        for (int o = 0; o < 4; o++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y += (o < 2) ? 1 : 5) begin
                    stream(1'b1, 2'(o), 8'(x), 8'(y));
                end
            end
        end
        stream(1'b0, 2'b00, 8'd0, 8'd0);
        stream(1'b0, 2'b00, 8'd0, 8'd0);
        @(negedge clk);
        chk("R2 hold after stream", res, e1 == e1 ? model(2'b11, 8'd255, 8'd255) : 16'h0);

        // Reset mid-operation with start high.
        drive(1'b1, 2'b01, 8'd200, 8'd3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset mid-run", res, 16'h0000);
        rst_n = 1'b1;
        drive(1'b0, 2'b01, 8'd9, 8'd9);
        repeat (2) @(negedge clk);
        chk("R9 cleared capture", res, 16'h0000);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule